// File: doc/BRIEF.md
# UART FIFO Trigger Threshold and Fill-Level Front End

This block sits beside the receive and transmit FIFOs of a UART channel. It decides when each FIFO has filled or drained far enough to ask for service. The FIFO storage is not part of the block. Each FIFO is represented only by an occupancy counter of `DEPTH` entries, 64 by default, which the push and pop strobes step up and down. From these counts and a set of control registers, the block drives three outputs:
- a receive service request,
- a transmit service request,
- a receive flow-control hold with programmable hysteresis.

Software reaches the block through a byte-wide register bus with an address, a write strobe and a read strobe. Some registers sit behind a bank key: they are reachable only while the line register holds 0xBF. The feature register chooses:
- one of four threshold tables;
- which direction a threshold write or a count read addresses;
- whether the scratch location returns the live FIFO count instead of its stored byte.

Tables A to C take a fixed level picked per direction by a level register. Table D takes one byte per direction, written through a single write-only threshold port.

Top module: `fifo_trig_front`

## Requirements
- R1: After reset both counts are 0, every register reads 0, the request for receive is low, the request for transmit is high, and the flow hold is low.
- R2: Each occupancy count stays within 0 to DEPTH. A push raises the count unless it is at DEPTH. A pop lowers the count unless it is 0. Both strobes are judged against the count from before the edge, so push plus pop moves DEPTH to DEPTH-1, moves 0 to 1, and leaves any other count unchanged.
- R3: With table select 0, 1 or 2, the receive threshold is a fixed level chosen by level register (address 2) bits 7:6, and the transmit threshold by bits 5:4. The codes 0, 1, 2 and 3 give 8, 16, 32 and 56.
- R4: With table select 3, the receive and transmit thresholds are the programmed threshold bytes.
- R5: A write to address 5 while the line register (address 3) holds 0xBF programs the receive threshold when direction bit 7 of the feature register is 0, and the transmit threshold when it is 1. A write to address 5 at any other time has no effect.
- R6: Address 5 always reads 0.
- R7: While unlocked, address 6 reads the receive count when the direction bit is 0 and the transmit count when it is 1.
- R8: Address 7 is a read/write scratch byte in both banks. When feature bit 6 (swap) is 1, a read of address 7 returns the selected count, chosen by the direction bit, instead of the scratch byte.
- R9: The receive request is high when receive count ≥ active receive threshold. The transmit request is high when transmit count ≤ active transmit threshold.
- R10: The flow hold is a register, with hysteresis span 4·H where H is feature bits 1:0 (reset 0):
  - it is set after any edge where receive count ≥ receive threshold;
  - it is cleared after an edge where receive count < threshold − 4·H, with that release level floored at 0;
  - otherwise it holds.
- R11: The feature register is at address 4, with table select in bits 5:4 and bits 3:2 reading 0. It is reachable only while unlocked; address 6 is likewise reachable only while unlocked. The level register is reachable only while locked. Any unreachable address ignores writes and reads 0, as do addresses 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (no side effects) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational while busRd is high |
| rxPush | input | 1 | Receive FIFO push strobe |
| rxPop | input | 1 | Receive FIFO pop strobe |
| txPush | input | 1 | Transmit FIFO push strobe |
| txPop | input | 1 | Transmit FIFO pop strobe |
| rxReq | output | 1 | Receive service request |
| txReq | output | 1 | Transmit service request |
| flowStop | output | 1 | Receive flow-control hold |

## Verification
The bench builds the block with its defaults: DEPTH of 64, a 3-bit address, and therefore a 7-bit count. With these values, a burst of 70 pushes or pops reaches both saturation edges. The fixed 56 level and programmed thresholds up to 71 reach all four table levels and thresholds that the count can never meet. Seeded random push and pop traffic runs with random table, direction, swap, hysteresis and bank settings. Directed cases cover simultaneous push and pop at full and at empty, and hysteresis release below the threshold.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] UNLOCK_KEY = 8'hBF;

  localparam int ADDR_LEVEL   = 2;
  localparam int ADDR_LINE    = 3;
  localparam int ADDR_FEAT    = 4;
  localparam int ADDR_THR     = 5;
  localparam int ADDR_COUNT   = 6;
  localparam int ADDR_SCRATCH = 7;

  localparam logic [BYTE_W-1:0] FEAT_MASK = 8'hF3;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_LEVEL,
    RD_LINE,
    RD_SCRATCH,
    RD_FEAT,
    RD_COUNT
  } rdSel_e;

  typedef struct packed {
    logic   wrLine;
    logic   wrLevel;
    logic   wrScratch;
    logic   wrFeat;
    logic   wrThr;
    rdSel_e rdSel;
  } busStrb_t;

  function automatic logic [BYTE_W-1:0] fixedLevel(input logic [1:0] code);
    logic [BYTE_W-1:0] lvl;
    case (code)
      2'd0:    lvl = 8'd8;
      2'd1:    lvl = 8'd16;
      2'd2:    lvl = 8'd32;
      default: lvl = 8'd56;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/fifo_occ_cnt.sv
module fifo_occ_cnt #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic doInc;
  logic doDec;

  assign doInc = push && (count != FULL);
  assign doDec = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({doInc, doDec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL) else $error("count above depth");

  p_sat_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL) && push && !pop |=> count == FULL) else $error("overflow past full");

  p_sat_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) && pop && !push |=> count == '0) else $error("underflow past empty");

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !push && !pop |=> $stable(count)) else $error("count moved while idle");

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              unlocked,
  input  logic              swapEn,
  output busStrb_t          strb
);

  int addrI;
  assign addrI = int'(busAddr);

  always_comb begin
    strb.wrLine    = busWr && (addrI == ADDR_LINE);
    strb.wrScratch = busWr && (addrI == ADDR_SCRATCH);
    strb.wrLevel   = busWr && !unlocked && (addrI == ADDR_LEVEL);
    strb.wrFeat    = busWr && unlocked && (addrI == ADDR_FEAT);
    strb.wrThr     = busWr && unlocked && (addrI == ADDR_THR);
    strb.rdSel     = RD_ZERO;
    if (busRd) begin
      case (addrI)
        ADDR_LEVEL:   strb.rdSel = unlocked ? RD_ZERO : RD_LEVEL;
        ADDR_LINE:    strb.rdSel = RD_LINE;
        ADDR_FEAT:    strb.rdSel = unlocked ? RD_FEAT : RD_ZERO;
        ADDR_COUNT:   strb.rdSel = unlocked ? RD_COUNT : RD_ZERO;
        ADDR_SCRATCH: strb.rdSel = swapEn ? RD_COUNT : RD_SCRATCH;
        default:      strb.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/fifo_trig_dp.sv
module fifo_trig_dp
  import fifo_trig_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  rxCnt,
  input  logic [CNT_W-1:0]  txCnt,
  output logic [BYTE_W-1:0] rdData,
  output logic              unlocked,
  output logic              swapEn,
  output logic              rxReq,
  output logic              txReq,
  output logic              flowStop
);

  logic [BYTE_W-1:0] lineReg;
  logic [BYTE_W-1:0] levelReg;
  logic [BYTE_W-1:0] scratchReg;
  logic [BYTE_W-1:0] featReg;
  logic [BYTE_W-1:0] rxThrProg;
  logic [BYTE_W-1:0] txThrProg;

  logic              dirSel;
  logic [1:0]        tableSel;
  logic [1:0]        hyst;
  logic [BYTE_W-1:0] rxThrAct;
  logic [BYTE_W-1:0] txThrAct;
  logic [BYTE_W-1:0] rxCntB;
  logic [BYTE_W-1:0] txCntB;
  logic [BYTE_W-1:0] selCnt;
  logic [BYTE_W-1:0] hystSpan;
  logic [BYTE_W-1:0] relLvl;

  assign unlocked = (lineReg == UNLOCK_KEY);
  assign dirSel   = featReg[7];
  assign swapEn   = featReg[6];
  assign tableSel = featReg[5:4];
  assign hyst     = featReg[1:0];

  assign rxCntB = BYTE_W'(rxCnt);
  assign txCntB = BYTE_W'(txCnt);
  assign selCnt = dirSel ? txCntB : rxCntB;

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg    <= '0;
      levelReg   <= '0;
      scratchReg <= '0;
      featReg    <= '0;
      rxThrProg  <= '0;
      txThrProg  <= '0;
    end else begin
      if (strb.wrLine)    lineReg    <= wrData;
      if (strb.wrLevel)   levelReg   <= wrData;
      if (strb.wrScratch) scratchReg <= wrData;
      if (strb.wrFeat)    featReg    <= wrData & FEAT_MASK;
      if (strb.wrThr) begin
        if (dirSel) txThrProg <= wrData;
        else        rxThrProg <= wrData;
      end
    end
  end

  // Threshold selection
  always_comb begin
    if (tableSel == 2'd3) begin
      rxThrAct = rxThrProg;
      txThrAct = txThrProg;
    end else begin
      rxThrAct = fixedLevel(levelReg[7:6]);
      txThrAct = fixedLevel(levelReg[5:4]);
    end
  end

  assign rxReq = (rxCntB >= rxThrAct);
  assign txReq = (txCntB <= txThrAct);

  // Flow hold with hysteresis
  assign hystSpan = BYTE_W'({hyst, 2'b00});
  assign relLvl   = (rxThrAct > hystSpan) ? (rxThrAct - hystSpan) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flowStop <= 1'b0;
    end else if (rxCntB >= rxThrAct) begin
      flowStop <= 1'b1;
    end else if (rxCntB < relLvl) begin
      flowStop <= 1'b0;
    end
  end

  // Readback
  always_comb begin
    case (strb.rdSel)
      RD_LEVEL:   rdData = levelReg;
      RD_LINE:    rdData = lineReg;
      RD_SCRATCH: rdData = scratchReg;
      RD_FEAT:    rdData = featReg;
      RD_COUNT:   rdData = selCnt;
      default:    rdData = '0;
    endcase
  end

  p_thr_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrThr |-> lineReg == UNLOCK_KEY) else $error("threshold write while locked");

  p_thr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrThr |=> $stable({rxThrProg, txThrProg})) else $error("threshold changed without write");

  p_feat_bank_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFeat |-> lineReg == UNLOCK_KEY) else $error("feature write while locked");

  p_cnt_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdSel == RD_COUNT |-> (unlocked || swapEn)) else $error("count read outside its windows");

  p_flow_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxReq |=> flowStop) else $error("flow hold missed threshold");

  p_flow_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    flowStop && (rxCntB >= relLvl) |=> flowStop) else $error("flow hold released inside band");

endmodule

// File: rtl/fifo_trig_front.sv
module fifo_trig_front
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic              txPush,
  input  logic              txPop,
  output logic              rxReq,
  output logic              txReq,
  output logic              flowStop
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NDIR  = 2;

  logic [NDIR-1:0]  pushV;
  logic [NDIR-1:0]  popV;
  logic [CNT_W-1:0] occ [NDIR];

  busStrb_t strb;
  logic     unlocked;
  logic     swapEn;

  assign pushV = {txPush, rxPush};
  assign popV  = {txPop, rxPop};

  for (genvar g = 0; g < NDIR; g++) begin : gDir
    fifo_occ_cnt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCnt (
      .clk   (clk),
      .rstN  (rstN),
      .push  (pushV[g]),
      .pop   (popV[g]),
      .count (occ[g])
    );
  end

  fifo_trig_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .unlocked (unlocked),
    .swapEn   (swapEn),
    .strb     (strb)
  );

  fifo_trig_dp #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (busWrData),
    .rxCnt    (occ[0]),
    .txCnt    (occ[1]),
    .rdData   (busRdData),
    .unlocked (unlocked),
    .swapEn   (swapEn),
    .rxReq    (rxReq),
    .txReq    (txReq),
    .flowStop (flowStop)
  );

endmodule

// File: tb/sim_fifo_trig_front.sv
`timescale 1ns/1ps
module sim_fifo_trig_front;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic       rxReq, txReq, flowStop;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_trig_front #(.DEPTH(DEPTH), .ADDR_W(3)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .rxReq(rxReq), .txReq(txReq), .flowStop(flowStop)
  );

  // Reference model
  logic [7:0] mLine, mLevel, mScratch, mFeat, mRxThr, mTxThr;
  int mRx, mTx;
  bit mFlow;

  function automatic int fixedLvl(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction

  function automatic int thrAct(input bit tx);
    if (mFeat[5:4] == 2'd3) return tx ? int'(mTxThr) : int'(mRxThr);
    return tx ? fixedLvl(mLevel[5:4]) : fixedLvl(mLevel[7:6]);
  endfunction

  function automatic int relLvl();
    int span = 4 * int'(mFeat[1:0]);
    int t = thrAct(0);
    return (t > span) ? t - span : 0;
  endfunction

  function automatic int nextCnt(input int c, input bit p, input bit q);
    int n = c;
    if (p && c != DEPTH) n = n + 1;
    if (q && c != 0) n = n - 1;
    return n;
  endfunction

  function automatic logic [7:0] expRead(input int a);
    bit unl = (mLine == 8'hBF);
    logic [7:0] sel = mFeat[7] ? 8'(mTx) : 8'(mRx);
    case (a)
      2: return unl ? 8'h00 : mLevel;
      3: return mLine;
      4: return unl ? mFeat : 8'h00;
      6: return unl ? sel : 8'h00;
      7: return mFeat[6] ? sel : mScratch;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLine <= 0; mLevel <= 0; mScratch <= 0; mFeat <= 0;
      mRxThr <= 0; mTxThr <= 0; mRx <= 0; mTx <= 0; mFlow <= 0;
    end else begin
      if (mRx >= thrAct(0)) mFlow <= 1;
      else if (mRx < relLvl()) mFlow <= 0;
      mRx <= nextCnt(mRx, rxPush, rxPop);
      mTx <= nextCnt(mTx, txPush, txPop);
      if (busWr) begin
        case (int'(busAddr))
          2: if (mLine != 8'hBF) mLevel <= busWrData;
          3: mLine <= busWrData;
          4: if (mLine == 8'hBF) mFeat <= busWrData & 8'hF3;
          5: if (mLine == 8'hBF) begin
               if (mFeat[7]) mTxThr <= busWrData;
               else mRxThr <= busWrData;
             end
          7: mScratch <= busWrData;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // Called shortly after a negedge: outputs reflect the last posedge
  task automatic cmpOuts(input string tag);
    bit eRx = (mRx >= thrAct(0));
    bit eTx = (mTx <= thrAct(1));
    check(rxReq == eRx, {tag, " rxReq R9"}, int'(rxReq), int'(eRx));
    check(txReq == eTx, {tag, " txReq R9"}, int'(txReq), int'(eTx));
    check(flowStop == mFlow, {tag, " flowStop R10"}, int'(flowStop), int'(mFlow));
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    busAddr = 3'(a); busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input int a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    busAddr = 3'(a); busRd = 1'b1;
    #1;
    e = expRead(a);
    check(busRdData == e, tag, int'(busRdData), int'(e));
    #1 busRd = 1'b0;
  endtask

  task automatic pulse(input bit rp, input bit rq, input bit tp, input bit tq,
                       input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.1 cmpOuts(tag);
      rxPush = rp; rxPop = rq; txPush = tp; txPop = tq;
    end
    @(negedge clk);
    rxPush = 0; rxPop = 0; txPush = 0; txPop = 0;
    #0.1 cmpOuts(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    #0.1;
    check(rxReq == 1'b0, "R1 rxReq after reset", int'(rxReq), 0);
    check(txReq == 1'b1, "R1 txReq after reset", int'(txReq), 1);
    check(flowStop == 1'b0, "R1 flowStop after reset", int'(flowStop), 0);
    busRead(3, "R1 line reg");
    busRead(7, "R1 scratch");
    busRead(2, "R1 level reg");

    // R11: feature write ignored while locked
    busWrite(4, 8'hFF);
    busRead(4, "R11 feature hidden when locked");
    busRead(6, "R11 count hidden when locked");
    busRead(0, "R11 unused address");
    busWrite(3, 8'hBF);
    busRead(4, "R11 locked write had no effect");
    busRead(6, "R7 rx count after reset");

    // R6: threshold is write-only
    busWrite(5, 8'h20);
    busRead(5, "R6 threshold reads zero");

    // R4: table D uses programmed rx threshold 32
    busWrite(4, 8'h3C);
    busRead(4, "R11 feature bits 3:2 read zero");
    busRead(2, "R11 level hidden when unlocked");
    pulse(1, 0, 0, 0, 32, "R4 rx programmed 32");

    // R5: tx threshold via direction bit, locked write ignored
    busWrite(4, 8'hB0);
    busWrite(5, 8'h05);
    busWrite(3, 8'h00);
    busWrite(5, 8'h01);
    pulse(0, 0, 1, 0, 6, "R5 tx programmed 5");
    busWrite(3, 8'hBF);
    busWrite(4, 8'h30);
    pulse(1, 1, 0, 0, 1, "R5 rx threshold unchanged by locked write");

    // R8: scratch and swap
    busWrite(7, 8'h5A);
    busRead(7, "R8 scratch readback");
    busWrite(4, 8'hF0);
    busRead(7, "R8 swap tx count");
    busRead(6, "R7 tx count");
    busWrite(4, 8'h70);
    busRead(7, "R8 swap rx count");
    busWrite(4, 8'h00);

    // R2: saturation and simultaneous strobes
    pulse(1, 0, 1, 0, 70, "R2 fill both");
    busRead(6, "R2 rx saturates at full");
    pulse(1, 1, 1, 1, 1, "R2 push+pop at full");
    busRead(6, "R2 push+pop at full gives depth-1");
    pulse(0, 1, 0, 1, 70, "R2 drain both");
    busRead(6, "R2 rx saturates at empty");
    pulse(1, 1, 0, 0, 1, "R2 push+pop at empty");
    busRead(6, "R2 push+pop at empty gives 1");
    pulse(0, 1, 0, 0, 1, "R2 back to empty");

    // R3 and R10: fixed levels 56/8 and hysteresis span 8
    busWrite(3, 8'h00);
    busWrite(2, 8'hC0);
    busWrite(3, 8'hBF);
    busWrite(4, 8'h02);
    pulse(1, 0, 1, 0, 56, "R3 rx fixed 56");
    pulse(0, 1, 0, 1, 8, "R10 inside band");
    pulse(0, 1, 0, 0, 2, "R10 below release");
    busWrite(4, 8'h00);
    busWrite(3, 8'h00);
    busWrite(2, 8'h60);
    pulse(1, 0, 0, 0, 4, "R3 levels 16 and 32");

    // Random traffic with random configuration
    for (int ph = 0; ph < 40; ph++) begin
      int pb = $urandom % 100;
      int qb = $urandom % 100;
      int tb = $urandom % 100;
      int ub = $urandom % 100;
      logic [7:0] f = 8'($urandom);
      busWrite(3, 8'h00);
      busWrite(2, 8'($urandom));
      busWrite(3, 8'hBF);
      busWrite(4, f & 8'h7F);
      busWrite(5, 8'($urandom % 72));
      busWrite(4, f | 8'h80);
      busWrite(5, 8'($urandom % 72));
      busWrite(4, f);
      busRead(4, "R11 random feature");
      if ($urandom % 2) busWrite(3, 8'h00);
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        #0.1 cmpOuts("random");
        rxPush = (($urandom % 100) < pb);
        rxPop  = (($urandom % 100) < qb);
        txPush = (($urandom % 100) < tb);
        txPop  = (($urandom % 100) < ub);
      end
      @(negedge clk);
      rxPush = 0; rxPop = 0; txPush = 0; txPop = 0;
      busRead(6, "R7 random count");
      busRead(7, "R8 random scratch/count");
      busRead(5, "R6 random threshold read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule